// File: doc/BRIEF.md
# Serial Flash Pause and Write-Protect Front End

This block sits at the slave-side edge of a serial NOR flash. It runs in one fast system clock domain. It brings the chip-select, serial-clock, data-in and pause pins through two-flop synchronizers and tracks the pause (hold) condition. Pause entry and exit are qualified by the serial clock level: a change on the pause pin that arrives while the serial clock is high takes effect only once the clock next goes low. While paused, no bits are shifted, the serial clock and data-in pins are ignored, and the data-out driver is turned off. A running internal write cycle, reported on a busy input, is not touched by the pause.

If the device is deselected while paused, the serial interface is held in reset. It is released only after the pause pin has been seen high while deselected and the device is then selected again. This keeps the interface from dropping straight back into a pause.

The same block decodes a 3-bit protect code into a top-down range of protected 64 KiB sectors. It answers, one cycle later, whether a requested read, program, sector erase or bulk erase may go ahead.

Top module: `flash_guard`

## Requirements
- R1: While reset is high and on the first cycle after it, pause_flag=0, dout_oe=0, shift_en=0 and if_reset=1.
- R2: A falling edge of pause_n_pin while cs_n_pin is low and sclk_pin is low sets pause_flag exactly 3 clk cycles after the pin change (still 0 after 2). If sclk_pin is high at the falling edge, pause_flag stays 0 until sclk_pin goes low, and is then set.
- R3: A rising edge of pause_n_pin while paused and sclk_pin is low clears pause_flag 3 clk cycles later. If sclk_pin is high at that edge, pause_flag stays 1 until sclk_pin goes low, and is then cleared.
- R4: While selected, not paused and not locked, each rising edge of sclk_pin gives exactly one shift_en pulse, and rx_bit then holds the level of din_pin at that edge. While paused, sclk_pin and din_pin toggles produce no shift_en pulse and leave rx_bit unchanged.
- R5: dout_oe is 1 only when the device is selected, not paused, not locked and out_phase=1. It is 0 in every cycle in which pause_flag is 1.
- R6: A pause can only begin on a pause_n_pin falling edge seen while selected. A fall while deselected, followed by selection with the pin still low, gives no pause.
- R7: Deselecting while paused clears pause_flag and locks the interface: if_reset=1, no shifts and dout_oe=0. The lock ends only once pause_n_pin is high while cs_n_pin is high. After that, selection gives if_reset=0.
- R8: busy_out equals busy_in delayed by one clk cycle, whatever the pause state.
- R9: The sector is tgt_addr[20:16]. The lowest protected sector for prot_code 0..7 is: none, 31, 30, 28, 24, 16, 0, 0; protection covers that sector up to 31. A program (op_kind=01) or sector erase (op_kind=10) into a protected sector gives op_allowed=0, otherwise 1. op_allowed is registered one cycle after the inputs.
- R10: A bulk erase (op_kind=11) gives op_allowed=1 only when prot_code=000.
- R11: A read (op_kind=00) always gives op_allowed=1.
- R12: if_reset is 1 whenever cs_n_pin is high (3 clk cycles of latency), and 0 while selected and not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sclk_pin | input | 1 | Serial clock pin |
| din_pin | input | 1 | Serial data-in pin |
| pause_n_pin | input | 1 | Pause pin, active low |
| out_phase | input | 1 | From the shift logic: the current phase drives data out |
| busy_in | input | 1 | Internal write cycle in progress |
| prot_code | input | 3 | Block-protect status bits |
| tgt_addr | input | 21 | Target byte address of the request |
| op_kind | input | 2 | 00 read, 01 program, 10 sector erase, 11 bulk erase |
| pause_flag | output | 1 | Pause condition active |
| dout_oe | output | 1 | Tristate enable of serial data out |
| shift_en | output | 1 | One-cycle pulse: shift one bit |
| rx_bit | output | 1 | Data-in bit captured at the last shift |
| if_reset | output | 1 | Hold the serial interface logic in reset |
| busy_out | output | 1 | Registered copy of busy_in |
| op_allowed | output | 1 | Requested operation permitted |

## Verification
Suppose the pause tracker holds a wrong state, such as a missed or stale pending entry, a lock that never clears, or a pause taken on the wrong clock level. Within three or four system cycles of the causing pin change, this shows up as pause_flag at the wrong level, a missing or extra shift_en pulse, or dout_oe driving while it should float. The bench therefore samples pause_flag at exactly the latency cycle and again around each serial clock transition, and it keeps a running shift count. A wrong protect decode shows up on op_allowed on the very next cycle. For that reason every protect code is swept against sectors on both sides of each range boundary, for all four operations.

// File: rtl/flash_guard_pkg.sv
`timescale 1ns/1ps
package flash_guard_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_PROG   = 2'b01,
    OP_SERASE = 2'b10,
    OP_BULK   = 2'b11
  } op_e;
endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pause_tracker.sv
`timescale 1ns/1ps
module pause_tracker (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic sck,
  input  logic din,
  input  logic pause_n,
  input  logic out_phase,
  output logic paused,
  output logic dout_oe,
  output logic shift_en,
  output logic rx_bit,
  output logic if_reset
);
  logic sck_q, pn_q;
  logic pend_in, pend_out, lock;
  logic paused_d, pend_in_d, pend_out_d, lock_d;
  logic pn_fall, pn_rise, sck_rise;

  assign pn_fall  = pn_q & ~pause_n;
  assign pn_rise  = ~pn_q & pause_n;
  assign sck_rise = sck & ~sck_q;

  always_comb begin
    paused_d   = paused;
    pend_in_d  = pend_in;
    pend_out_d = pend_out;
    lock_d     = lock;
    if (sel_n) begin
      // deselected: an interrupted pause leaves the interface locked
      lock_d     = (lock | paused | pend_out) & ~pause_n;
      paused_d   = 1'b0;
      pend_in_d  = 1'b0;
      pend_out_d = 1'b0;
    end else if (!lock) begin
      if (!paused) begin
        if (pn_fall) begin
          if (!sck) paused_d = 1'b1;
          else      pend_in_d = 1'b1;
        end else if (pend_in) begin
          if (pause_n) pend_in_d = 1'b0;
          else if (!sck) begin
            paused_d  = 1'b1;
            pend_in_d = 1'b0;
          end
        end
      end else begin
        if (pn_rise) begin
          if (!sck) paused_d = 1'b0;
          else      pend_out_d = 1'b1;
        end else if (pend_out) begin
          if (!pause_n) pend_out_d = 1'b0;
          else if (!sck) begin
            paused_d   = 1'b0;
            pend_out_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      pn_q     <= 1'b1;
      paused   <= 1'b0;
      pend_in  <= 1'b0;
      pend_out <= 1'b0;
      lock     <= 1'b0;
      shift_en <= 1'b0;
      rx_bit   <= 1'b0;
      dout_oe  <= 1'b0;
      if_reset <= 1'b1;
    end else begin
      sck_q    <= sck;
      pn_q     <= pause_n;
      paused   <= paused_d;
      pend_in  <= pend_in_d;
      pend_out <= pend_out_d;
      lock     <= lock_d;
      shift_en <= ~sel_n & ~lock_d & ~paused_d & sck_rise;
      if (~sel_n & ~lock_d & ~paused_d & sck_rise) rx_bit <= din;
      dout_oe  <= ~sel_n & ~lock_d & ~paused_d & out_phase;
      if_reset <= sel_n | lock_d;
    end
  end

  // R5: data out never driven during a pause
  assert_oe_off_in_pause_R5: assert property (@(posedge clk) disable iff (rst)
    paused |-> !dout_oe);
  // R4: no shifting during a pause
  assert_no_shift_in_pause_R4: assert property (@(posedge clk) disable iff (rst)
    paused |-> !shift_en);
  // R2: pause only begins on a low serial clock
  assert_enter_low_clk_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(paused) |-> !$past(sck));
  // R3: pause only ends on a low serial clock or by deselection
  assert_exit_low_clk_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(paused) && !$past(sel_n)) |-> !$past(sck));
  // R7 / R12: deselection clears pause and resets the interface
  assert_desel_resets_R7: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> (!paused && if_reset));
endmodule

// File: rtl/protect_decode.sv
`timescale 1ns/1ps
module protect_decode
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        prot,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        op_kind,
  output logic              op_allowed
);
  localparam int NSECT = 1 << SECT_W;

  logic [SECT_W-1:0] sector;
  logic [SECT_W:0]   prot_cnt;
  logic [SECT_W:0]   reach;
  logic              in_prot;
  logic              allow_d;
  logic              unused_low;

  assign sector     = addr[ADDR_W-1 -: SECT_W];
  assign unused_low = ^addr[ADDR_W-SECT_W-1:0];

  // number of protected sectors counted down from the top one
  always_comb begin
    if (prot == 3'd0)       prot_cnt = '0;
    else if (prot >= 3'd6)  prot_cnt = (SECT_W+1)'(NSECT);
    else if ((32'd1 << (prot - 3'd1)) >= 32'(NSECT)) prot_cnt = (SECT_W+1)'(NSECT);
    else                    prot_cnt = (SECT_W+1)'(32'd1 << (prot - 3'd1));
  end

  assign reach   = {1'b0, sector} + prot_cnt;
  assign in_prot = reach >= (SECT_W+1)'(NSECT);

  always_comb begin
    case (op_e'(op_kind))
      OP_READ:            allow_d = 1'b1;
      OP_PROG, OP_SERASE: allow_d = ~in_prot;
      default:            allow_d = (prot == 3'd0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) op_allowed <= 1'b0;
    else     op_allowed <= allow_d;
  end

  // R10: bulk erase locked out by any protect bit
  assert_bulk_interlock_R10: assert property (@(posedge clk) disable iff (rst)
    (op_kind == 2'b11 && prot != 3'd0) |=> !op_allowed);
  // R11: reads always go ahead
  assert_read_always_R11: assert property (@(posedge clk) disable iff (rst)
    (op_kind == 2'b00) |=> op_allowed);
  // R9: top sector is protected under every nonzero code
  assert_top_sector_R9: assert property (@(posedge clk) disable iff (rst)
    (op_kind == 2'b01 && prot != 3'd0 && sector == SECT_W'(NSECT-1)) |=> !op_allowed);
endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard #(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_pin,
  input  logic              sclk_pin,
  input  logic              din_pin,
  input  logic              pause_n_pin,
  input  logic              out_phase,
  input  logic              busy_in,
  input  logic [2:0]        prot_code,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [1:0]        op_kind,
  output logic              pause_flag,
  output logic              dout_oe,
  output logic              shift_en,
  output logic              rx_bit,
  output logic              if_reset,
  output logic              busy_out,
  output logic              op_allowed
);
  logic [3:0] pins_s;

  pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pause_n_pin, din_pin, sclk_pin, cs_n_pin}),
    .q   (pins_s)
  );

  pause_tracker u_track (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (pins_s[0]),
    .sck       (pins_s[1]),
    .din       (pins_s[2]),
    .pause_n   (pins_s[3]),
    .out_phase (out_phase),
    .paused    (pause_flag),
    .dout_oe   (dout_oe),
    .shift_en  (shift_en),
    .rx_bit    (rx_bit),
    .if_reset  (if_reset)
  );

  protect_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_prot (
    .clk        (clk),
    .rst        (rst),
    .prot       (prot_code),
    .addr       (tgt_addr),
    .op_kind    (op_kind),
    .op_allowed (op_allowed)
  );

  // write cycle status passes through untouched by the pause state
  always_ff @(posedge clk) begin
    if (rst) busy_out <= 1'b0;
    else     busy_out <= busy_in;
  end

  // R8: busy is a pure one-cycle delay
  assert_busy_passes_R8: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(busy_in) |=> (busy_out == $past(busy_in)));
endmodule

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n_pin = 1'b1, sclk_pin = 1'b0, din_pin = 1'b0, pause_n_pin = 1'b1;
  logic out_phase = 1'b0, busy_in = 1'b0;
  logic [2:0]  prot_code = 3'd0;
  logic [20:0] tgt_addr = '0;
  logic [1:0]  op_kind = 2'b00;
  logic pause_flag, dout_oe, shift_en, rx_bit, if_reset, busy_out, op_allowed;

  always #4 clk = ~clk;

  flash_guard u0 (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin),
    .din_pin(din_pin), .pause_n_pin(pause_n_pin), .out_phase(out_phase),
    .busy_in(busy_in), .prot_code(prot_code), .tgt_addr(tgt_addr),
    .op_kind(op_kind), .pause_flag(pause_flag), .dout_oe(dout_oe),
    .shift_en(shift_en), .rx_bit(rx_bit), .if_reset(if_reset),
    .busy_out(busy_out), .op_allowed(op_allowed)
  );

  localparam int F_PAUSE = 0, F_OE = 1, F_IFR = 2, F_ALLOW = 3,
                 F_BUSY = 4, F_SHIFTS = 5, F_RX = 6;

  typedef struct {
    string tag;
    int    fld;
    int    exp;
  } item_t;

  item_t q[$];
  int applied = 0, miscomp = 0;
  int shifts = 0, exp_shifts = 0;
  bit done = 1'b0;

  // monitor: count shift pulses, then pop and compare expected items
  always @(negedge clk) begin
    int act;
    if (!rst && shift_en === 1'b1) shifts++;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      case (it.fld)
        F_PAUSE:  act = int'(pause_flag);
        F_OE:     act = int'(dout_oe);
        F_IFR:    act = int'(if_reset);
        F_ALLOW:  act = int'(op_allowed);
        F_BUSY:   act = int'(busy_out);
        F_SHIFTS: act = shifts;
        default:  act = int'(rx_bit);
      endcase
      applied++;
      if (act != it.exp) begin
        miscomp++;
        $display("FAIL %s field %0d: actual %0d expected %0d", it.tag, it.fld, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_val(input string tag, input int fld, input int e);
    item_t it;
    it.tag = tag; it.fld = fld; it.exp = e;
    q.push_back(it);
  endtask

  task automatic sck_bit(input logic b, input bit counts);
    din_pin = b;
    sclk_pin = 1'b1;
    step(4);
    if (counts) exp_shifts++;
    sclk_pin = 1'b0;
    step(4);
  endtask

  function automatic int low_sector(input int code);
    case (code)
      0: return 32;
      1: return 31;
      2: return 30;
      3: return 28;
      4: return 24;
      5: return 16;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  end

  initial begin
    int sects[10] = '{0, 15, 16, 23, 24, 27, 28, 29, 30, 31};
    step(3);
    expect_val("R1 reset pause", F_PAUSE, 0);
    expect_val("R1 reset oe", F_OE, 0);
    expect_val("R1 reset ifr", F_IFR, 1);
    step(2);
    rst = 1'b0;
    step(1);
    expect_val("R1 post pause", F_PAUSE, 0);
    expect_val("R1 post ifr", F_IFR, 1);

    // R12 / R5: select and deselect
    cs_n_pin = 1'b0; out_phase = 1'b1;
    step(4);
    expect_val("R12 selected ifr", F_IFR, 0);
    expect_val("R5 oe selected", F_OE, 1);
    out_phase = 1'b0;
    step(2);
    expect_val("R5 oe input phase", F_OE, 0);
    out_phase = 1'b1;
    cs_n_pin = 1'b1;
    step(4);
    expect_val("R12 deselected ifr", F_IFR, 1);
    expect_val("R5 oe deselected", F_OE, 0);

    // R4: shift a byte
    cs_n_pin = 1'b0;
    step(4);
    for (int i = 7; i >= 0; i--) begin
      sck_bit(8'hA5 >> i, 1'b1);
      expect_val("R4 rx bit", F_RX, (8'hA5 >> i) & 1);
    end
    expect_val("R4 shift count", F_SHIFTS, exp_shifts);

    // R2 immediate entry, exact latency
    pause_n_pin = 1'b0;
    step(2);
    expect_val("R2 latency not yet", F_PAUSE, 0);
    step(1);
    expect_val("R2 entered", F_PAUSE, 1);
    expect_val("R5 oe off in pause", F_OE, 0);
    sck_bit(1'b0, 1'b0);
    sck_bit(1'b1, 1'b0);
    sck_bit(1'b0, 1'b0);
    expect_val("R4 no shifts paused", F_SHIFTS, exp_shifts);
    expect_val("R4 rx kept paused", F_RX, 1);
    // R3 immediate exit
    pause_n_pin = 1'b1;
    step(2);
    expect_val("R3 latency not yet", F_PAUSE, 1);
    step(1);
    expect_val("R3 exited", F_PAUSE, 0);
    step(1);
    expect_val("R5 oe back", F_OE, 1);

    // R2 deferred entry
    din_pin = 1'b0;
    sclk_pin = 1'b1;
    step(4);
    exp_shifts++;
    pause_n_pin = 1'b0;
    step(6);
    expect_val("R2 deferred still 0", F_PAUSE, 0);
    sclk_pin = 1'b0;
    step(3);
    expect_val("R2 deferred entered", F_PAUSE, 1);
    // R3 deferred exit
    sclk_pin = 1'b1;
    step(4);
    pause_n_pin = 1'b1;
    step(6);
    expect_val("R3 deferred still 1", F_PAUSE, 1);
    sclk_pin = 1'b0;
    step(3);
    expect_val("R3 deferred exited", F_PAUSE, 0);
    expect_val("R4 shifts around deferral", F_SHIFTS, exp_shifts);

    // R8 busy through a pause
    pause_n_pin = 1'b0;
    step(4);
    expect_val("R8 paused for busy", F_PAUSE, 1);
    busy_in = 1'b1;
    step(1);
    expect_val("R8 busy high", F_BUSY, 1);
    busy_in = 1'b0;
    step(1);
    expect_val("R8 busy low", F_BUSY, 0);

    // R7 deselect during pause locks the interface
    cs_n_pin = 1'b1;
    step(4);
    expect_val("R7 pause cleared", F_PAUSE, 0);
    expect_val("R7 ifr on", F_IFR, 1);
    cs_n_pin = 1'b0;
    step(4);
    expect_val("R7 locked no pause", F_PAUSE, 0);
    expect_val("R7 locked ifr", F_IFR, 1);
    expect_val("R7 locked oe", F_OE, 0);
    sck_bit(1'b1, 1'b0);
    expect_val("R7 locked no shift", F_SHIFTS, exp_shifts);
    pause_n_pin = 1'b1;
    step(4);
    expect_val("R7 still locked while selected", F_IFR, 1);
    cs_n_pin = 1'b1;
    step(4);
    cs_n_pin = 1'b0;
    step(4);
    expect_val("R7 released ifr", F_IFR, 0);
    expect_val("R7 released oe", F_OE, 1);
    sck_bit(1'b1, 1'b1);
    expect_val("R7 shifting again", F_SHIFTS, exp_shifts);

    // R6 pause needs selection at the falling edge
    cs_n_pin = 1'b1;
    pause_n_pin = 1'b0;
    step(4);
    cs_n_pin = 1'b0;
    step(4);
    expect_val("R6 no pause", F_PAUSE, 0);
    expect_val("R6 ifr clear", F_IFR, 0);
    pause_n_pin = 1'b1;
    step(4);

    // R9 / R10 / R11 protect sweep
    for (int code = 0; code < 8; code++) begin
      for (int s = 0; s < 10; s++) begin
        for (int op = 0; op < 4; op++) begin
          int e;
          prot_code = 3'(code);
          tgt_addr = {5'(sects[s]), 16'h5A3C};
          op_kind = 2'(op);
          if (op == 0) e = 1;
          else if (op == 3) e = (code == 0) ? 1 : 0;
          else e = (sects[s] >= low_sector(code)) ? 0 : 1;
          step(1);
          if (op == 0) expect_val("R11 read", F_ALLOW, e);
          else if (op == 3) expect_val("R10 bulk", F_ALLOW, e);
          else expect_val("R9 prog/serase", F_ALLOW, e);
        end
      end
    end

    step(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end
endmodule